// File: doc/BRIEF.md
# UDP Payload Realigner and Session Demultiplexer

This block sits behind a header filter on the receive side of a 10G Ethernet path. It takes the 32-bit receive word stream, removes the 42 bytes of Ethernet, IPv4 and UDP header, and delivers the datagram payload as aligned 32-bit words. The first payload byte is placed on output bits 7:0. Because the header length is not a multiple of four, each payload word is built from the low half of one input word and the high half of the next. The path adds one register of latency.

The header filter gives a per-session verdict alongside the stream, and a checksum unit reports a checksum-bad flag with the last input word. The realigner latches the verdict on the eleventh input word. It drives one bit of a four-bit valid vector, so the payload reaches only the matching session. Data, byte enables, start, end and the error field are shared by all sessions. The UDP length field sets where the payload ends, so any Ethernet padding behind the datagram is dropped. The error bits are filled in from the frame's last input word.

Upstream guarantees that every frame carries at least the bytes its UDP length field announces.

Top module: `udp_payload_realign`

## Requirements
- R1: While reset is asserted, and after it is released, every output is 0 until a packet is delivered: valid vector, data, byte enable, start, end and error.
- R2: The first payload word is driven in the cycle after the 12th input word (index 11) is accepted, with `pl_sop`=1. Exactly one word of each packet carries `pl_sop` and exactly one carries `pl_eop`.
- R3: Input byte k of a word is on `rx_data` bits [31-8k -: 8]. Output payload byte 4n+k of word n is on `pl_data` bits [8k+7:8k]. Payload byte 0 is frame byte 42.
- R4: `rx_sess_hit` is sampled on the 11th input word (index 10). If it is one-hot, only that bit of `pl_valid` is set for the packet's words. If it is zero or has more than one bit set, the packet produces no output. At most one `pl_valid` bit is 1 in any cycle.
- R5: `pl_be` is 1111b on every word except the last. For the last word it is 0001b, 0011b, 0111b or 1111b when 1, 2, 3 or 4 payload bytes remain.
- R6: When the UDP length ends exactly at the frame end, the last word appears in the cycle after the final input word if 3 or 4 payload bytes remain in it. If only 1 or 2 remain and the payload is longer than 2 bytes, the last two words take two consecutive cycles and the last appears one cycle later.
- R7: A cycle with no accepted input word during the payload produces no output word in the following cycle.
- R8: On the last word, `pl_err` bit 0 equals `rx_csum_bad` and bit 1 equals `rx_err`, both sampled with the frame's last input word. Bits 7:2 are always 0, and the field is 0 on other words. Flagged packets are still delivered whole.
- R9: Bytes beyond the UDP length are discarded. If padding follows, the last word is held and emitted in the cycle after the frame's last input word.
- R10: The UDP length is the big-endian 16-bit field at frame bytes 38 and 39 (input word 9, bits 15:0). Payload length is that value minus 8. A value of 8 or less produces no output.
- R11: A payload of 1 or 2 bytes produces a single word with `pl_sop`=`pl_eop`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for stream and outputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 32 | Receive word, first byte on bits 31:24 |
| rx_valid | input | 1 | Receive word valid |
| rx_eop | input | 1 | Last word of the frame |
| rx_err | input | 1 | Frame error, meaningful with `rx_eop` |
| rx_csum_bad | input | 1 | UDP checksum bad, meaningful with `rx_eop` |
| rx_sess_hit | input | 4 | Session verdict, one-hot, meaningful on word 10 |
| pl_data | output | 32 | Payload word, first byte on bits 7:0 |
| pl_be | output | 4 | Byte enables of `pl_data` |
| pl_sop | output | 1 | First payload word |
| pl_eop | output | 1 | Last payload word |
| pl_err | output | 8 | Error flags on the last word |
| pl_valid | output | 4 | One-hot per-session valid |

## Verification
Frames are generated with payload lengths that cover every remainder from 1 to 4 bytes. Exact-fit frames are separated from padded frames, which tells the two-cycle tail apart from the held last word. Idle gaps inside the payload show that output valid follows the input. The verdict is driven wrong on every word but the eleventh, and the error flags are driven inverted on every word but the last, so any sampling at the wrong word shows up. Zero-length datagrams, undersized length fields and zero or multi-bit verdicts must produce no words.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_BYTES    = 4;
  localparam int WORD_W        = BYTE_W * WORD_BYTES;
  localparam int HALF_W        = WORD_W / 2;
  localparam int LEN_W         = 16;
  localparam int HDR_BYTES     = 42;
  localparam int UDP_HDR_BYTES = 8;
  // word holding the UDP length field in its low half (bytes 36..39)
  localparam int LEN_WORD_IDX  = 9;
  // word holding the last header half and the first payload half
  localparam int SPLIT_IDX     = HDR_BYTES / WORD_BYTES;
  localparam int IDX_W         = $clog2(SPLIT_IDX + 1);

  typedef enum logic [1:0] {
    TRK_HDR  = 2'd0,
    TRK_PAY  = 2'd1,
    TRK_SKIP = 2'd2
  } trk_state_e;

  // big-endian half of an input word to little-endian output order
  function automatic logic [HALF_W-1:0] swap_half(input logic [HALF_W-1:0] h);
    return {h[BYTE_W-1:0], h[HALF_W-1:BYTE_W]};
  endfunction

  function automatic logic [WORD_BYTES-1:0] be_of(input logic [2:0] n);
    case (n)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/udp_hdr_tracker.sv
module udp_hdr_tracker
  import udp_rx_pkg::*;
#(
  parameter int NUM_SESS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_eop,
  input  logic [HALF_W-1:0]    in_low,
  input  logic [NUM_SESS-1:0]  sess_in,
  input  logic                 merge_done,
  output logic                 pay_start,
  output logic [LEN_W-1:0]     pay_len,
  output logic                 in_body,
  output logic [NUM_SESS-1:0]  sess_q
);
  trk_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] ulen_q;
  logic             len_ld;
  logic             at_split;
  logic             sess_ok;

  assign sess_ok   = (sess_in != '0) && ((sess_in & (sess_in - 1'b1)) == '0);
  assign pay_len   = (ulen_q > LEN_W'(UDP_HDR_BYTES)) ? ulen_q - LEN_W'(UDP_HDR_BYTES) : '0;
  assign at_split  = in_valid && (st_q == TRK_HDR) && (idx_q == IDX_W'(SPLIT_IDX));
  assign pay_start = at_split && sess_ok && (pay_len != '0);
  assign in_body   = in_valid && (st_q == TRK_PAY);
  assign len_ld    = in_valid && (st_q == TRK_HDR) && (idx_q == IDX_W'(LEN_WORD_IDX));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (in_valid && in_eop) begin
      st_d  = TRK_HDR;
      idx_d = '0;
    end else begin
      case (st_q)
        TRK_HDR: begin
          if (in_valid) begin
            if (idx_q == IDX_W'(SPLIT_IDX)) begin
              if (pay_start && (pay_len > LEN_W'(2))) st_d = TRK_PAY;
              else                                    st_d = TRK_SKIP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        TRK_PAY:  if (merge_done) st_d = TRK_SKIP;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_HDR;
      idx_q  <= '0;
      ulen_q <= '0;
      sess_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (len_ld)    ulen_q <= in_low;
      if (pay_start) sess_q <= sess_in;
    end
  end

  // a session is latched only when the verdict is one-hot
  assert_sess_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_start |=> $onehot(sess_q));

  // a length field of 8 or less never opens the payload phase
  assert_short_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (at_split && ulen_q <= LEN_W'(UDP_HDR_BYTES)) |=> (st_q != TRK_PAY));
endmodule

// File: rtl/udp_tail_merge.sv
module udp_tail_merge
  import udp_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_eop,
  input  logic                  in_err,
  input  logic                  csum_bad,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  pay_start,
  input  logic [LEN_W-1:0]      pay_len,
  input  logic                  in_body,
  output logic                  emit,
  output logic [WORD_W-1:0]     emit_data,
  output logic [WORD_BYTES-1:0] emit_be,
  output logic                  emit_last,
  output logic [1:0]            emit_err,
  output logic                  merge_done
);
  logic [HALF_W-1:0]     lo_q, lo_d, lo_n, hi_n;
  logic                  lo_ld;
  logic [LEN_W-1:0]      rem_q, rem_d;
  logic                  rem_ld;
  logic                  pend_v_q, pend_v_d;
  logic                  pend_done_q, pend_done_d;
  logic [WORD_W-1:0]     pend_data_q;
  logic [WORD_BYTES-1:0] pend_be_q;
  logic [1:0]            pend_err_q;
  logic                  dir_v;
  logic [WORD_W-1:0]     dir_data;
  logic                  fin_v;
  logic [WORD_W-1:0]     fin_data;
  logic [WORD_BYTES-1:0] fin_be;
  logic                  eop_now, fin_direct, pend_set, pend_fire;
  logic [1:0]            err_now;

  assign lo_n    = swap_half(in_data[HALF_W-1:0]);
  assign hi_n    = swap_half(in_data[WORD_W-1:HALF_W]);
  assign eop_now = in_valid && in_eop;
  assign err_now = {in_err, csum_bad};

  always_comb begin
    dir_v      = 1'b0;
    dir_data   = {hi_n, lo_q};
    fin_v      = 1'b0;
    fin_data   = {hi_n, lo_q};
    fin_be     = '1;
    lo_ld      = 1'b0;
    lo_d       = lo_n;
    rem_ld     = 1'b0;
    rem_d      = rem_q;
    merge_done = 1'b0;
    if (pay_start) begin
      if (pay_len <= LEN_W'(2)) begin
        fin_v    = 1'b1;
        fin_data = {{HALF_W{1'b0}}, lo_n};
        fin_be   = be_of(pay_len[2:0]);
      end else begin
        lo_ld  = 1'b1;
        rem_ld = 1'b1;
        rem_d  = pay_len;
      end
    end else if (in_body) begin
      if (rem_q > LEN_W'(4)) begin
        dir_v  = 1'b1;
        lo_ld  = 1'b1;
        rem_ld = 1'b1;
        rem_d  = rem_q - LEN_W'(4);
        if (rem_q <= LEN_W'(6)) begin
          fin_v      = 1'b1;
          fin_data   = {{HALF_W{1'b0}}, lo_n};
          fin_be     = be_of(rem_d[2:0]);
          merge_done = 1'b1;
        end
      end else begin
        fin_v      = 1'b1;
        fin_data   = {hi_n, lo_q};
        fin_be     = be_of(rem_q[2:0]);
        merge_done = 1'b1;
      end
    end
  end

  assign fin_direct = fin_v && !dir_v && eop_now;
  assign pend_set   = fin_v && !fin_direct;
  assign pend_fire  = pend_v_q && (pend_done_q || eop_now);

  assign emit      = dir_v || fin_direct || pend_fire;
  assign emit_last = fin_direct || pend_fire;
  assign emit_data = dir_v ? dir_data : (fin_direct ? fin_data : pend_data_q);
  assign emit_be   = dir_v ? '1 : (fin_direct ? fin_be : pend_be_q);
  assign emit_err  = (pend_fire && pend_done_q) ? pend_err_q : err_now;

  always_comb begin
    pend_v_d    = pend_v_q;
    pend_done_d = pend_done_q;
    if (pend_set) begin
      pend_v_d    = 1'b1;
      pend_done_d = eop_now;
    end else if (pend_fire) begin
      pend_v_d    = 1'b0;
      pend_done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q        <= '0;
      rem_q       <= '0;
      pend_v_q    <= 1'b0;
      pend_done_q <= 1'b0;
      pend_data_q <= '0;
      pend_be_q   <= '0;
      pend_err_q  <= '0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_done_q <= pend_done_d;
      if (lo_ld)  lo_q  <= lo_d;
      if (rem_ld) rem_q <= rem_d;
      if (pend_set) begin
        pend_data_q <= fin_data;
        pend_be_q   <= fin_be;
      end
      if (pend_set && eop_now) pend_err_q <= err_now;
    end
  end

  // a held last word never overlaps a payload word of any packet
  assert_pend_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> !(in_body || pay_start));

  // a non-final word leaves only when an input word arrives
  assert_gap_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !emit_last) |-> in_valid);

  // a held tail with the frame already closed leaves on the next cycle
  assert_tail_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && eop_now) |=> (emit && emit_last));
endmodule

// File: rtl/udp_out_stage.sv
module udp_out_stage
  import udp_rx_pkg::*;
#(
  parameter int NUM_SESS = 4,
  parameter int ERR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  emit,
  input  logic                  emit_last,
  input  logic                  pkt_start,
  input  logic [WORD_W-1:0]     emit_data,
  input  logic [WORD_BYTES-1:0] emit_be,
  input  logic [1:0]            emit_err,
  input  logic [NUM_SESS-1:0]   sess,
  output logic [WORD_W-1:0]     out_data,
  output logic [WORD_BYTES-1:0] out_be,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [ERR_W-1:0]      out_err,
  output logic [NUM_SESS-1:0]   out_valid
);
  logic                sop_due_q, sop_due_d;
  logic                sop_now;
  logic [NUM_SESS-1:0] valid_d;
  logic [ERR_W-1:0]    err_d;

  assign sop_now = pkt_start || sop_due_q;
  assign err_d   = (emit && emit_last) ? {{(ERR_W-2){1'b0}}, emit_err} : '0;

  always_comb begin
    sop_due_d = sop_due_q;
    if (pkt_start) sop_due_d = 1'b1;
    if (emit)      sop_due_d = 1'b0;
  end

  for (genvar s = 0; s < NUM_SESS; s++) begin : g_vld
    assign valid_d[s] = emit && sess[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_due_q <= 1'b0;
      out_valid <= '0;
      out_data  <= '0;
      out_be    <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_err   <= '0;
    end else begin
      sop_due_q <= sop_due_d;
      out_valid <= valid_d;
      out_sop   <= emit && sop_now;
      out_eop   <= emit && emit_last;
      out_err   <= err_d;
      if (emit) begin
        out_data <= emit_data;
        out_be   <= emit_be;
      end
    end
  end

  assert_valid_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  assert_full_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) && !out_eop) |-> (out_be == '1));

  assert_last_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) && out_eop) |->
      (out_be == 4'b0001 || out_be == 4'b0011 || out_be == 4'b0111 || out_be == 4'b1111));

  assert_err_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|out_valid) && out_eop) |-> (out_err == '0));

  assert_err_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err[ERR_W-1:2] == '0);

  // no second start before the current packet has ended
  assert_sop_after_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) && out_sop && !out_eop) |=> !((|out_valid) && out_sop));
endmodule

// File: rtl/udp_payload_realign.sv
module udp_payload_realign
  import udp_rx_pkg::*;
#(
  parameter int NUM_SESS = 4,
  parameter int ERR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           rx_data,
  input  logic                  rx_valid,
  input  logic                  rx_eop,
  input  logic                  rx_err,
  input  logic                  rx_csum_bad,
  input  logic [NUM_SESS-1:0]   rx_sess_hit,
  output logic [31:0]           pl_data,
  output logic [3:0]            pl_be,
  output logic                  pl_sop,
  output logic                  pl_eop,
  output logic [ERR_W-1:0]      pl_err,
  output logic [NUM_SESS-1:0]   pl_valid
);
  logic [1:0]            rst_pipe;
  logic                  core_rst_n;
  logic                  pay_start, in_body, merge_done;
  logic [LEN_W-1:0]      pay_len;
  logic [NUM_SESS-1:0]   sess_q;
  logic                  emit, emit_last;
  logic [WORD_W-1:0]     emit_data;
  logic [WORD_BYTES-1:0] emit_be;
  logic [1:0]            emit_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  udp_hdr_tracker #(.NUM_SESS(NUM_SESS)) u_trk (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .in_valid   (rx_valid),
    .in_eop     (rx_eop),
    .in_low     (rx_data[HALF_W-1:0]),
    .sess_in    (rx_sess_hit),
    .merge_done (merge_done),
    .pay_start  (pay_start),
    .pay_len    (pay_len),
    .in_body    (in_body),
    .sess_q     (sess_q)
  );

  udp_tail_merge u_mrg (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .in_valid   (rx_valid),
    .in_eop     (rx_eop),
    .in_err     (rx_err),
    .csum_bad   (rx_csum_bad),
    .in_data    (rx_data),
    .pay_start  (pay_start),
    .pay_len    (pay_len),
    .in_body    (in_body),
    .emit       (emit),
    .emit_data  (emit_data),
    .emit_be    (emit_be),
    .emit_last  (emit_last),
    .emit_err   (emit_err),
    .merge_done (merge_done)
  );

  udp_out_stage #(.NUM_SESS(NUM_SESS), .ERR_W(ERR_W)) u_out (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .emit       (emit),
    .emit_last  (emit_last),
    .pkt_start  (pay_start),
    .emit_data  (emit_data),
    .emit_be    (emit_be),
    .emit_err   (emit_err),
    .sess       (pay_start ? rx_sess_hit : sess_q),
    .out_data   (pl_data),
    .out_be     (pl_be),
    .out_sop    (pl_sop),
    .out_eop    (pl_eop),
    .out_err    (pl_err),
    .out_valid  (pl_valid)
  );
endmodule

// File: tb/udp_payload_realign_bench.sv
module udp_payload_realign_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int NVEC = 15;
  localparam int VW   = 31;
  typedef logic [VW-1:0] vec_t;
  // {udp_len[15:0], pad_bytes[7:0], verdict[3:0], csum_bad, rx_err, gaps}
  localparam vec_t VECS [NVEC] = '{
    {16'd24, 8'd0,  4'b0001, 1'b0, 1'b0, 1'b0},
    {16'd25, 8'd0,  4'b0010, 1'b0, 1'b0, 1'b0},
    {16'd26, 8'd0,  4'b0100, 1'b0, 1'b1, 1'b0},
    {16'd27, 8'd0,  4'b1000, 1'b1, 1'b0, 1'b0},
    {16'd21, 8'd0,  4'b0001, 1'b0, 1'b0, 1'b1},
    {16'd13, 8'd10, 4'b0010, 1'b0, 1'b0, 1'b0},
    {16'd10, 8'd14, 4'b0001, 1'b0, 1'b0, 1'b0},
    {16'd9,  8'd0,  4'b1000, 1'b1, 1'b1, 1'b0},
    {16'd8,  8'd18, 4'b0001, 1'b0, 1'b0, 1'b0},
    {16'd4,  8'd18, 4'b0001, 1'b0, 1'b0, 1'b0},
    {16'd28, 8'd0,  4'b0000, 1'b0, 1'b0, 1'b0},
    {16'd28, 8'd0,  4'b0011, 1'b0, 1'b0, 1'b0},
    {16'd38, 8'd0,  4'b0100, 1'b1, 1'b0, 1'b1},
    {16'd14, 8'd0,  4'b0001, 1'b0, 1'b0, 1'b0},
    {16'd10, 8'd0,  4'b0010, 1'b0, 1'b1, 1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic [31:0]   rx_data;
  logic          rx_valid, rx_eop, rx_err, rx_csum_bad;
  logic [NS-1:0] rx_sess_hit;
  logic [31:0]   pl_data;
  logic [3:0]    pl_be;
  logic          pl_sop, pl_eop;
  logic [7:0]    pl_err;
  logic [NS-1:0] pl_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0]    fb [0:127];
  logic [31:0]   mo_data [0:31];
  logic [3:0]    mo_be   [0:31];
  logic          mo_sop  [0:31];
  logic          mo_eop  [0:31];
  logic [7:0]    mo_err  [0:31];
  logic [NS-1:0] mo_vld  [0:31];
  int            mo_cyc  [0:31];
  int            mo_n = 0;

  udp_payload_realign u_udp_payload_realign (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_eop(rx_eop), .rx_err(rx_err), .rx_csum_bad(rx_csum_bad),
    .rx_sess_hit(rx_sess_hit), .pl_data(pl_data), .pl_be(pl_be),
    .pl_sop(pl_sop), .pl_eop(pl_eop), .pl_err(pl_err), .pl_valid(pl_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pl_valid != '0 && mo_n < 32) begin
      mo_data[mo_n] = pl_data;
      mo_be[mo_n]   = pl_be;
      mo_sop[mo_n]  = pl_sop;
      mo_eop[mo_n]  = pl_eop;
      mo_err[mo_n]  = pl_err;
      mo_vld[mo_n]  = pl_valid;
      mo_cyc[mo_n]  = cyc;
      mo_n = mo_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int p, input int v);
    return 8'(p * 13 + v * 29 + 1);
  endfunction

  task automatic run_vec(input int v);
    logic [15:0] udpl;
    int pad, len, tot, nw, nexp, r, w11c, eopc, tail;
    logic [3:0] sess;
    logic cs, er, gap, last, ok, onehot;
    logic [31:0] a_w, e_w;
    logic [3:0] e_be;
    udpl = VECS[v][30:15];
    pad  = int'(VECS[v][14:7]);
    sess = VECS[v][6:3];
    cs   = VECS[v][2];
    er   = VECS[v][1];
    gap  = VECS[v][0];
    len  = (udpl > 16'd8) ? int'(udpl) - 8 : 0;
    tot  = 42 + len + pad;
    nw   = (tot + 3) / 4;
    onehot = (sess != 0) && ((sess & (sess - 4'd1)) == 0);
    nexp = (onehot && len > 0) ? (len + 3) / 4 : 0;
    r    = (len > 0) ? ((len - 1) % 4) + 1 : 0;
    w11c = 0;
    eopc = 0;
    for (int b = 0; b < 128; b++) begin
      if (b >= tot)            fb[b] = 8'h00;
      else if (b >= 42 + len)  fb[b] = 8'hEE;
      else if (b >= 42)        fb[b] = pay(b - 42, v);
      else                     fb[b] = 8'hA0 ^ 8'(b);
    end
    fb[38] = udpl[15:8];
    fb[39] = udpl[7:0];
    repeat (3) @(negedge clk);
    mo_n = 0;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      last = (i == nw - 1);
      rx_valid    = 1'b1;
      rx_data     = {fb[4*i], fb[4*i+1], fb[4*i+2], fb[4*i+3]};
      rx_eop      = last;
      rx_err      = last ? er : !er;
      rx_csum_bad = last ? cs : !cs;
      rx_sess_hit = (i == 10) ? sess : ~sess;
      if (i == 11) w11c = cyc + 1;
      if (last)    eopc = cyc + 1;
      if (gap && (i % 3 == 2) && !last && i >= 11) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eop   = 1'b0;
        @(negedge clk);
        chk(pl_valid == '0, "R7 gap", 32'(pl_valid), 32'h0);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_eop   = 1'b0;
    repeat (4) @(negedge clk);

    if (!onehot)        chk(mo_n == nexp, "R4 rejected verdict", 32'(mo_n), 32'(nexp));
    else if (len == 0)  chk(mo_n == nexp, "R10 empty datagram", 32'(mo_n), 32'(nexp));
    else if (len <= 2)  chk(mo_n == nexp, "R11 short payload", 32'(mo_n), 32'(nexp));
    else                chk(mo_n == nexp, "R2 word count", 32'(mo_n), 32'(nexp));
    if (nexp == 0 || mo_n != nexp) return;

    // payload bytes in little-endian order
    ok = 1'b1; a_w = '0; e_w = '0;
    for (int k = 0; k < nexp; k++) begin
      logic [31:0] aw, ew;
      aw = '0; ew = '0;
      for (int j = 0; j < 4; j++)
        if (4*k + j < len) begin
          ew[8*j +: 8] = pay(4*k + j, v);
          aw[8*j +: 8] = mo_data[k][8*j +: 8];
        end
      if (ok && aw != ew) begin ok = 1'b0; a_w = aw; e_w = ew; end
    end
    chk(ok, "R3 payload bytes", a_w, e_w);

    ok = 1'b1; a_w = '0; e_w = '0;
    for (int k = 0; k < nexp; k++) begin
      e_be = (k < nexp - 1) ? 4'hF : 4'((1 << r) - 1);
      if (ok && mo_be[k] != e_be) begin ok = 1'b0; a_w = 32'(mo_be[k]); e_w = 32'(e_be); end
    end
    chk(ok, "R5 byte enable", a_w, e_w);

    ok = 1'b1;
    for (int k = 0; k < nexp; k++)
      if (mo_vld[k] != sess) ok = 1'b0;
    chk(ok, "R4 session valid", 32'(mo_vld[0]), 32'(sess));

    ok = 1'b1;
    for (int k = 0; k < nexp; k++)
      if (mo_sop[k] != (k == 0) || mo_eop[k] != (k == nexp - 1)) ok = 1'b0;
    chk(ok, "R2 sop/eop marks", {mo_sop[0], mo_eop[nexp-1]}, 32'h3);

    ok = 1'b1;
    for (int k = 0; k < nexp - 1; k++)
      if (mo_err[k] != 8'h00) ok = 1'b0;
    chk(ok && mo_err[nexp-1] == {6'b0, er, cs}, "R8 error field",
        32'(mo_err[nexp-1]), 32'({6'b0, er, cs}));

    if (len > 2)
      chk(mo_cyc[0] == w11c, "R2 first word latency", 32'(mo_cyc[0]), 32'(w11c));
    tail = (len > 2 && r <= 2 && pad == 0) ? 1 : 0;
    if (pad > 0)
      chk(mo_cyc[nexp-1] == eopc, "R9 padded tail", 32'(mo_cyc[nexp-1]), 32'(eopc));
    else
      chk(mo_cyc[nexp-1] == eopc + tail, "R6 tail timing", 32'(mo_cyc[nexp-1]), 32'(eopc + tail));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_eop = 1'b0; rx_err = 1'b0; rx_csum_bad = 1'b0;
    rx_data = '0; rx_sess_hit = '0;
    repeat (3) @(negedge clk);
    chk(pl_valid == '0 && !pl_sop && !pl_eop && pl_err == '0 && pl_data == '0 && pl_be == '0,
        "R1 in reset", {pl_valid, pl_be, pl_sop, pl_eop, pl_err}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pl_valid == '0 && !pl_sop && !pl_eop && pl_err == '0 && pl_data == '0,
        "R1 after release", {pl_valid, pl_sop, pl_eop, pl_err}, 32'h0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // reset arriving in the middle of a payload clears all outputs
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      rx_valid    = 1'b1;
      rx_data     = (i == 9) ? 32'h0000_0030 : 32'h1122_3344 + 32'(i);
      rx_eop      = 1'b0;
      rx_sess_hit = 4'b0001;
    end
    rst_n = 1'b0;
    #1;
    chk(pl_valid == '0 && !pl_sop && !pl_eop, "R1 mid-frame reset",
        {pl_valid, pl_sop, pl_eop}, 32'h0);
    @(negedge clk);
    rx_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule